// File: doc/BRIEF.md
# Sequential Non-Restoring Divider

This unit divides a 32-bit unsigned dividend by a 32-bit unsigned divisor over a fixed run of clock cycles. Each cycle resolves one quotient bit with the non-restoring method: the partial remainder is shifted left, and the divisor is added to it or taken from it depending on its sign. The unit applies no correction after the final bit, so the remainder it reports is the raw partial remainder and can be negative (bit 31 set).

A mode input selects plain integer division or 16.16 fixed-point division. In fixed-point mode the upper half of the dividend is placed in the partial remainder, and the lower half is placed in the upper half of the quotient register before the first step. This yields a quotient with 16 fraction bits. The surrounding datapath pulses a start strobe, watches the busy flag and the one-cycle done pulse, and reads the quotient and remainder outputs, which hold their values until the next accepted start.

Top module: `nrdiv_unit`

## Requirements
- R1: A start pulse sampled while the unit is idle is accepted. It captures the dividend, divisor and mode, and busy is high from the next cycle on.
- R2: An accepted operation performs exactly 32 iterations. Done is high in the 33rd cycle after the start edge.
- R3: Each iteration tests the sign of the partial remainder before the shift. A negative value (bit 31 = 1) adds the divisor, and a non-negative value subtracts it. The shift brings in the quotient register's bit 31 as the new LSB, and the new quotient bit, shifted into the quotient LSB, is the inverse of bit 31 of the updated remainder.
- R4: In integer mode (mode = 0) the partial remainder starts at zero and the quotient register starts at the dividend. For example, 5 / 2 gives quotient 2.
- R5: In fixed-point mode (mode = 1) the partial remainder starts as dividend[31:16] in its low half. The quotient register starts as dividend[15:0] in its high half, with zeros below.
- R6: No correction step follows the last iteration, and a negative final remainder is reported as is. For example, 5 / 2 in integer mode gives remainder 0xFFFFFFFF.
- R7: A zero divisor runs the normal 32 iterations and reports whatever they produce.
- R8: A start pulse while busy is ignored. The running operation's result and completion cycle do not change.
- R9: Done is high for exactly one cycle, and busy falls in that same cycle.
- R10: Quotient and remainder hold their values after completion until the next accepted start.
- R11: Reset idles the unit and clears quotient and remainder to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe, sampled when idle |
| mode_i | input | 1 | 0 = integer, 1 = 16.16 fixed point |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Raw partial remainder |

## Verification
The bench drives the start strobe on a falling edge and counts falling edges after it. Busy must read high at the first of these, and done must first read high at the 33rd, with busy already low. Done must be low again at the 34th. Quotient and remainder are compared against a bit-exact model of the same loop at the done cycle, and again after ten further idle cycles. A start pulse injected in the fifth busy cycle must move neither the done cycle nor the result. Because every sample is taken at a falling edge, each value has settled a half period after the rising edge that produced it.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic {
    DIV_INT = 1'b0,
    DIV_FIX = 1'b1
  } div_mode_e;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic         neg;
  logic [W-1:0] shifted;

  always_comb begin
    neg     = rem_i[W-1];
    shifted = {rem_i[W-2:0], quo_i[W-1]};
    rem_o   = neg ? (shifted + dsr_i) : (shifted - dsr_i);
    quo_o   = {quo_i[W-2:0], ~rem_o[W-1]};
  end
endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign accept_o = start_i && !busy_q;
  assign step_o   = busy_q;
  assign last     = busy_q && (cnt_q == LAST);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = last;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
  p_iter_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && $past(cnt_q) == LAST));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit
  import nrdiv_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [31:0]  dividend_i,
  input  logic [31:0]  divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [31:0]  quotient_o,
  output logic [31:0]  remainder_o
);
  localparam int HI = W - FRAC;

  logic         accept, step;
  logic [W-1:0] rem_q, rem_d, quo_q, quo_d, dsr_q, dsr_d;
  logic [W-1:0] rem_nx, quo_nx;

  nrdiv_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  nrdiv_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dsr_i (dsr_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dsr_d = dsr_q;
    if (accept) begin
      dsr_d = divisor_i;
      if (div_mode_e'(mode_i) == DIV_FIX) begin
        rem_d = dividend_i >> FRAC;
        quo_d = dividend_i << HI;
      end else begin
        rem_d = '0;
        quo_d = dividend_i;
      end
    end else if (step) begin
      rem_d = rem_nx;
      quo_d = quo_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dsr_q <= dsr_d;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
  p_step_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rem_q[W-1]) |=> (quo_q[0] == !rem_q[W-1]));
  p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));
endmodule

// File: tb/nrdiv_unit_bench.sv
module nrdiv_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        mode_i;
  logic [31:0] dividend_i;
  logic [31:0] divisor_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] quotient_o;
  logic [31:0] remainder_o;

  int n_chk;
  int n_fail;

  nrdiv_unit u_nrdiv_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] n, input logic [31:0] d,
                                        input logic fix);
    logic [31:0] q;
    logic [31:0] r;
    logic        s;
    q = fix ? (n << 16) : n;
    r = fix ? (n >> 16) : 32'd0;
    for (int i = 0; i < 32; i++) begin
      s = r[31];
      r = {r[30:0], q[31]};
      r = s ? r + d : r - d;
      q = {q[30:0], ~r[31]};
    end
    return {q, r};
  endfunction

  // Runs one operation; poke injects a start with other operands while busy (R8)
  task automatic run_op(input logic [31:0] n, input logic [31:0] d, input logic fix,
                        input bit poke, input string tag);
    logic [63:0] exp;
    int          cyc;
    exp = model(n, d, fix);
    @(negedge clk);
    start_i = 1'b1; mode_i = fix; dividend_i = n; divisor_i = d;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    chk({tag, " R1 busy after start"}, 32'(busy_o), 32'd1);
    while (!done_o && cyc < 40) begin
      if (poke && cyc == 5) begin
        start_i = 1'b1; mode_i = ~fix; dividend_i = ~n; divisor_i = d + 32'd3;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    chk({tag, " R2 done cycle"}, 32'(cyc), 32'd33);
    chk({tag, " R9 busy low at done"}, 32'(busy_o), 32'd0);
    chk({tag, " R3 quotient"}, quotient_o, exp[63:32]);
    chk({tag, " R6 remainder"}, remainder_o, exp[31:0]);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(done_o), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 32'(busy_o), 32'd0);
    chk("R11 quotient in reset", quotient_o, 32'd0);
    chk("R11 remainder in reset", remainder_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 done after reset", 32'(done_o), 32'd0);
  endtask

  task automatic t_known;
    run_op(32'd5, 32'd2, 1'b0, 1'b0, "int5/2");
    chk("R4 5/2 quotient", quotient_o, 32'd2);
    chk("R6 5/2 negative remainder", remainder_o, 32'hFFFF_FFFF);
    run_op(32'd100, 32'd7, 1'b0, 1'b0, "int100/7");
    run_op(32'h0003_8000, 32'h0001_0000, 1'b1, 1'b0, "R5 fix");
  endtask

  task automatic t_corners;
    run_op(32'hDEAD_BEEF, 32'd1, 1'b0, 1'b0, "div1");
    chk("R4 div by 1", quotient_o, 32'hDEAD_BEEF);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "divmax");
    run_op(32'd0, 32'd9, 1'b0, 1'b0, "zero dividend");
    run_op(32'd0, 32'd9, 1'b1, 1'b0, "zero dividend fix");
    run_op(32'h1234_5678, 32'd0, 1'b0, 1'b0, "R7 zero divisor int");
    run_op(32'h1234_5678, 32'd0, 1'b1, 1'b0, "R7 zero divisor fix");
    run_op(32'h0007_0000, 32'd1, 1'b1, 1'b0, "fix div1");
  endtask

  task automatic t_busy_start;
    run_op(32'd1000, 32'd33, 1'b0, 1'b1, "R8 poke");
    chk("R8 result kept", quotient_o, 32'd30);
  endtask

  task automatic t_hold;
    logic [31:0] q0, r0;
    run_op(32'h0ABC_DEF0, 32'd77, 1'b1, 1'b0, "hold");
    q0 = quotient_o; r0 = remainder_o;
    mode_i = 1'b0; dividend_i = 32'h5555_5555; divisor_i = 32'd3;
    repeat (10) @(negedge clk);
    chk("R10 quotient held", quotient_o, q0);
    chk("R10 remainder held", remainder_o, r0);
  endtask

  task automatic t_random;
    logic [31:0] n, d;
    for (int i = 0; i < 40; i++) begin
      n = $urandom;
      d = (i % 3 == 0) ? ($urandom & 32'h0000_FFFF) : $urandom;
      run_op(n, d, 1'(i % 2), 1'b0, (i % 2) ? "R5 rnd fix" : "R4 rnd int");
    end
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; dividend_i = 32'd77; divisor_i = 32'd5;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 busy cleared mid-run", 32'(busy_o), 32'd0);
    chk("R11 quotient cleared mid-run", quotient_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    t_reset();
    t_known();
    t_corners();
    t_busy_start();
    t_hold();
    t_random();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule